// File: doc/BRIEF.md
# Address-Strobed Bit Set/Clear Configuration Register

This block holds a 16-bit system configuration word that a processor changes without putting anything on the data bus. A window of 32 consecutive addresses is reserved for it. Each configuration bit owns two neighbouring addresses in that window. A write to the even address of a pair clears that bit, and a write to the odd address sets it. Software therefore changes any single bit with one store to the right address. The value it stores does not matter, so the block has no data input at all.

The word is presented as decoded fields:
- a 3-bit video addressing mode;
- a 7-bit video base offset;
- a 32K page select;
- a 2-bit processor rate;
- a 2-bit memory size;
- a memory map type bit.

All state is held in one flop per bit. A synchronous active-low reset puts every bit at zero. The zero state is the normal map, the slow rate, the smallest memory size, page 0 and offset 0.

Top module: `strobe_ctl_reg`

## Requirements
- R1: A cycle with `rst_n` low makes all sixteen bits zero from the next clock edge, so every field output reads 0.
- R2: A qualified write whose address is inside FFC0h..FFDFh and is odd sets the selected bit to 1.
- R3: A qualified write whose address is inside FFC0h..FFDFh and is even clears the selected bit to 0.
- R4: Address bits 4..1 select the bit index. Indices 0..2 are vid_mode bits 0..2, indices 3..9 are vid_offset bits 0..6, index 10 is page_sel, indices 11..12 are cpu_rate bits 0..1, indices 13..14 are mem_size bits 0..1 and index 15 is map_type. So FFC0h/FFC1h reach vid_mode bit 0 and FFDEh/FFDFh reach map_type.
- R5: Field outputs present their bits with the higher index as the more significant bit.
- R6: Writes to addresses outside FFC0h..FFDFh leave every bit unchanged. This includes the neighbours FFBFh and FFE0h.
- R7: A cycle with `bus_wr` low is a read and leaves every bit unchanged, even at an address in the window.
- R8: A cycle with `bus_valid` low leaves every bit unchanged, even when `bus_wr` is high and the address is in the window.
- R9: A qualified write changes only the one selected bit. The other fifteen bits hold their values.
- R10: A change made at a clock edge is visible on the outputs right after that edge, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Processor address bus |
| bus_wr | input | 1 | High for a write cycle, low for a read |
| bus_valid | input | 1 | Qualifies the bus cycle for this clock edge |
| vid_mode | output | 3 | Video addressing mode field |
| vid_offset | output | 7 | Video base offset field, in 512-byte units |
| page_sel | output | 1 | Selects which 32K page the lower half of the map uses |
| cpu_rate | output | 2 | Processor rate field |
| mem_size | output | 2 | Memory size field |
| map_type | output | 1 | Memory map type |

## Verification
The checker rebuilds the 16-bit word from the field ports on every cycle. From that word it checks four things:
- a non-qualified cycle or an out-of-window address leaves the word stable;
- a qualified write lands the address LSB in the selected bit one edge later;
- no other bit moves on that write;
- the word is zero after reset.

What those checks cannot show is the index-to-field mapping and the bit order within each field. The bench covers these by walking every address in the window. It also checks named fields with specific patterns and probes the addresses just outside the window.

// File: rtl/strobe_ctl_pkg.sv
// Package: shared sizes and field positions for the strobe-addressed
// configuration register. Assumes the bit index order below is fixed,
// because software addresses each bit by its place in the window.
package strobe_ctl_pkg;
    localparam int ADDR_W   = 16;
    localparam int NBITS    = 16;
    localparam int IDX_W    = $clog2(NBITS);
    localparam logic [ADDR_W-1:0] WIN_BASE = 16'hFFC0;

    localparam int MODE_LSB = 0;
    localparam int MODE_W   = 3;
    localparam int OFS_LSB  = MODE_LSB + MODE_W;
    localparam int OFS_W    = 7;
    localparam int PAGE_POS = OFS_LSB + OFS_W;
    localparam int RATE_LSB = PAGE_POS + 1;
    localparam int RATE_W   = 2;
    localparam int SIZE_LSB = RATE_LSB + RATE_W;
    localparam int SIZE_W   = 2;
    localparam int MAP_POS  = SIZE_LSB + SIZE_W;

    typedef struct packed {
        logic              hit;
        logic [IDX_W-1:0]  idx;
        logic              val;
    } strobe_req_t;
endpackage

// File: rtl/strobe_ctl_decode.sv
// Module: strobe_ctl_decode
// Turns one bus cycle into a set/clear request. It assumes the window base
// is aligned to 2*NBITS. The upper address bits must match the window, the
// bits just above the LSB name the bit, and the LSB is the value to store.
module strobe_ctl_decode
    import strobe_ctl_pkg::*;
#(
    parameter int                AW    = ADDR_W,
    parameter int                NB    = NBITS,
    parameter logic [AW-1:0]     BASE  = WIN_BASE
) (
    input  logic [AW-1:0]        addr,
    input  logic                 wr,
    input  logic                 valid,
    output strobe_req_t          req
);
    localparam int IW  = $clog2(NB);
    localparam int TOP = AW - 1;
    localparam int WLO = IW + 1;
    localparam logic [TOP-WLO:0] WIN_TAG = BASE[TOP:WLO];

    // Combine qualification and window match into one request record.
    always_comb begin
        req.hit = valid && wr && (addr[TOP:WLO] == WIN_TAG);
        req.idx = addr[IW:1];
        req.val = addr[0];
    end
endmodule

// File: rtl/strobe_ctl_bits.sv
// Module: strobe_ctl_bits
// Bank of NB independent flops. Only the flop named by the request index
// is written, and it takes the request value. Reset is synchronous and
// active-low and clears every flop.
module strobe_ctl_bits
    import strobe_ctl_pkg::*;
#(
    parameter int NB = NBITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  strobe_req_t   req,
    output logic [NB-1:0] q
);
    for (genvar i = 0; i < NB; i++) begin : g_bit
        // Hold this bit unless the request targets its index.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else if (req.hit && (req.idx == i))
                q[i] <= req.val;
        end
    end
endmodule

// File: rtl/strobe_ctl_reg.sv
// Module: strobe_ctl_reg (top)
// Configuration register written by address strobes alone. It assumes a
// single-clock bus where bus_valid marks the edge at which the cycle counts.
// The decoded fields come straight from the bit bank.
module strobe_ctl_reg
    import strobe_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       bus_addr,
    input  logic              bus_wr,
    input  logic              bus_valid,
    output logic [2:0]        vid_mode,
    output logic [6:0]        vid_offset,
    output logic              page_sel,
    output logic [1:0]        cpu_rate,
    output logic [1:0]        mem_size,
    output logic              map_type
);
    strobe_req_t        req;
    logic [NBITS-1:0]   word;

    strobe_ctl_decode #(.AW(ADDR_W), .NB(NBITS), .BASE(WIN_BASE)) u_dec (
        .addr  (bus_addr),
        .wr    (bus_wr),
        .valid (bus_valid),
        .req   (req)
    );

    strobe_ctl_bits #(.NB(NBITS)) u_bits (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .q     (word)
    );

    // Slice the stored word into its named fields.
    always_comb begin
        vid_mode   = word[MODE_LSB +: MODE_W];
        vid_offset = word[OFS_LSB  +: OFS_W];
        page_sel   = word[PAGE_POS];
        cpu_rate   = word[RATE_LSB +: RATE_W];
        mem_size   = word[SIZE_LSB +: SIZE_W];
        map_type   = word[MAP_POS];
    end
endmodule

// File: rtl/strobe_ctl_reg_chk.sv
// Module: strobe_ctl_reg_chk
// Checker bound to strobe_ctl_reg. It sees only the top module's ports. It
// rebuilds the word from the field outputs and compares each cycle with the
// bus cycle registered one edge before.
module strobe_ctl_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] bus_addr,
    input logic        bus_wr,
    input logic        bus_valid,
    input logic [2:0]  vid_mode,
    input logic [6:0]  vid_offset,
    input logic        page_sel,
    input logic [1:0]  cpu_rate,
    input logic [1:0]  mem_size,
    input logic        map_type
);
    logic [15:0] w;
    logic        in_win;
    logic        p_hit;
    logic [3:0]  p_idx;
    logic        p_val;
    logic [15:0] p_word;

    // Rebuild the word from the port fields and classify the current cycle.
    always_comb begin
        w      = {map_type, mem_size, cpu_rate, page_sel, vid_offset, vid_mode};
        in_win = bus_valid && bus_wr && (bus_addr >= 16'hFFC0) && (bus_addr <= 16'hFFDF);
    end

    // Remember the previous cycle's request and word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_hit  <= 1'b0;
            p_idx  <= '0;
            p_val  <= 1'b0;
            p_word <= '0;
        end else begin
            p_hit  <= in_win;
            p_idx  <= bus_addr[4:1];
            p_val  <= bus_addr[0];
            p_word <= w;
        end
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (w == 16'h0000));

    // R6 R7 R8
    no_hit_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_win |=> $stable(w));

    // R2 R3
    bit_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p_hit |-> (w[p_idx] == p_val));

    // R9
    single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p_hit |-> (((w ^ p_word) & ~(16'(1) << p_idx)) == 16'h0000));
endmodule

bind strobe_ctl_reg strobe_ctl_reg_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_valid  (bus_valid),
    .vid_mode   (vid_mode),
    .vid_offset (vid_offset),
    .page_sel   (page_sel),
    .cpu_rate   (cpu_rate),
    .mem_size   (mem_size),
    .map_type   (map_type)
);

// File: tb/strobe_ctl_reg_test.sv
// Scoreboard bench for strobe_ctl_reg. Each cycle the driver applies one bus
// cycle, updates a model word and pushes the expected word with its tag. A
// monitor pops one item a quarter period after each rising edge and compares.
module strobe_ctl_reg_test;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_valid = 1'b0;
    logic [2:0]  vid_mode;
    logic [6:0]  vid_offset;
    logic        page_sel;
    logic [1:0]  cpu_rate;
    logic [1:0]  mem_size;
    logic        map_type;

    item_t       sb[$];
    logic [15:0] model = '0;
    int          total = 0;
    int          bad = 0;
    logic        done = 1'b0;

    strobe_ctl_reg uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_valid(bus_valid), .vid_mode(vid_mode), .vid_offset(vid_offset),
        .page_sel(page_sel), .cpu_rate(cpu_rate), .mem_size(mem_size),
        .map_type(map_type)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] port_word();
        return {map_type, mem_size, cpu_rate, page_sel, vid_offset, vid_mode};
    endfunction

    task automatic check(input logic ok, input string tag,
                         input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle at the falling edge and push the expected word.
    task automatic step(input logic rst, input logic v, input logic wr,
                        input logic [15:0] a, input string tag);
        item_t it;
        @(negedge clk);
        rst_n = rst; bus_valid = v; bus_wr = wr; bus_addr = a;
        if (!rst)
            model = '0;
        else if (v && wr && a >= 16'hFFC0 && a <= 16'hFFDF)
            model[a[4:1]] = a[0];
        it.exp = model;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: compare one expected item per rising edge, away from the edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (sb.size() != 0) begin
                item_t it;
                it = sb.pop_front();
                check(port_word() == it.exp, it.tag, port_word(), it.exp);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) step(1'b0, 1'b0, 1'b0, 16'h0000, "R1 reset");
        // R2 R4 R10 R9: set each bit in turn by odd addresses
        for (int i = 0; i < 16; i++)
            step(1'b1, 1'b1, 1'b1, 16'hFFC1 + 16'(2*i), "R2 R9 R10 set walk");
        // R3: clear in reverse order by even addresses
        for (int i = 15; i >= 0; i--)
            step(1'b1, 1'b1, 1'b1, 16'hFFC0 + 16'(2*i), "R3 R9 clear walk");
        drain();
        // R4 R5: named field patterns
        step(1'b1, 1'b1, 1'b1, 16'hFFC1, "R4 mode0");
        step(1'b1, 1'b1, 1'b1, 16'hFFC5, "R4 mode2");
        step(1'b1, 1'b1, 1'b1, 16'hFFC9, "R4 ofs1");
        step(1'b1, 1'b1, 1'b1, 16'hFFD3, "R4 ofs6");
        step(1'b1, 1'b1, 1'b1, 16'hFFD5, "R4 page");
        step(1'b1, 1'b1, 1'b1, 16'hFFD9, "R4 rate1");
        step(1'b1, 1'b1, 1'b1, 16'hFFDB, "R4 size0");
        step(1'b1, 1'b1, 1'b1, 16'hFFDF, "R4 map");
        drain();
        check(vid_mode == 3'd5, "R5 vid_mode", 16'(vid_mode), 16'd5);
        check(vid_offset == 7'h42, "R5 vid_offset", 16'(vid_offset), 16'h42);
        check(page_sel == 1'b1, "R4 page_sel", 16'(page_sel), 16'd1);
        check(cpu_rate == 2'b10, "R5 cpu_rate", 16'(cpu_rate), 16'd2);
        check(mem_size == 2'b01, "R5 mem_size", 16'(mem_size), 16'd1);
        check(map_type == 1'b1, "R4 map_type", 16'(map_type), 16'd1);
        // R6: neighbours just outside the window, odd and even
        step(1'b1, 1'b1, 1'b1, 16'hFFBF, "R6 below odd");
        step(1'b1, 1'b1, 1'b1, 16'hFFBE, "R6 below even");
        step(1'b1, 1'b1, 1'b1, 16'hFFE0, "R6 above even");
        step(1'b1, 1'b1, 1'b1, 16'hFFE1, "R6 above odd");
        step(1'b1, 1'b1, 1'b1, 16'h7FC0, "R6 alias low");
        // R7: reads in the window
        step(1'b1, 1'b1, 1'b0, 16'hFFC0, "R7 read even");
        step(1'b1, 1'b1, 1'b0, 16'hFFC3, "R7 read odd");
        // R8: unqualified writes in the window
        step(1'b1, 1'b0, 1'b1, 16'hFFDE, "R8 invalid clear");
        step(1'b1, 1'b0, 1'b1, 16'hFFC3, "R8 invalid set");
        // R9: repeated set is idempotent, then a clear amid set bits
        step(1'b1, 1'b1, 1'b1, 16'hFFDF, "R9 reset same bit");
        step(1'b1, 1'b1, 1'b1, 16'hFFC8, "R9 single clear");
        // R10: back-to-back set then clear of one bit
        step(1'b1, 1'b1, 1'b1, 16'hFFD7, "R10 set rate0");
        step(1'b1, 1'b1, 1'b1, 16'hFFD6, "R10 clear rate0");
        // R1: reset mid-run overrides a simultaneous write
        step(1'b0, 1'b1, 1'b1, 16'hFFDD, "R1 reset over write");
        step(1'b1, 1'b0, 1'b0, 16'h0000, "R1 after reset");
        drain();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule